// File: doc/BRIEF.md
# Masked Interrupt Collector

The block gathers up to sixteen level-style request lines from board peripherals and presents them to a host processor as one active-low summary line. Every request line is brought into the local clock domain through a two-stage synchronizer. A synchronized high level sets a sticky pending bit. The host reads and writes two 32-bit registers over a simple address/write-enable/data bus. One register holds a per-source enable mask. The other holds the pending flags, and software clears a flag by writing zero to its position.

The host watches the summary line with a falling-edge detector. The line therefore goes low while any enabled flag is pending, and it returns high once every enabled flag has been cleared, so that the next request creates a fresh edge. A service routine reads the pending flags, ANDs them with the enable mask and handles the lowest set position first. It repeats this until nothing enabled remains.

A flag cannot be cleared while its synchronized source is still active. This prevents a request that is still held from being lost.

Top module: `irq_collector`

## Requirements
- R1: Positions 8 and 12 have no source connected. Their pending bits always read 0, whatever appears on `src_i[8]` or `src_i[12]`.
- R2: The enable register is at byte offset 0xC0 and the pending register at 0xD0. Both return their 16-bit value in read data bits 15:0 with bits 31:16 at 0. All 16 enable bits can be written and read back.
- R3: A write to 0xD0 clears each pending bit whose write-data bit is 0, if that source is inactive. Bits written as 1 keep their value.
- R4: While a synchronized source is high, its pending bit is set every cycle, and a clear written in the same cycle is ignored (set wins).
- R5: A source passes through a two-flop synchronizer. A rise on `src_i` that comes just after a clock edge shows in the pending register after the third following rising edge, and not after the second.
- R6: `irq_n_o` is registered. One cycle after (pending AND enable) becomes nonzero it goes low. One cycle after that value becomes zero it goes high again.
- R7: Synchronous active-high reset clears the enable register, the pending register and the synchronizer, and drives `irq_n_o` high.
- R8: A pending bit stays set after its source drops until software clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr_i | input | 8 | Register byte offset |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed register, combinational |
| src_i | input | 16 | Request lines, active high |
| irq_n_o | output | 1 | Summary request, active low |

## Verification
The hardest case to reach from the ports is a clear that lands while the source is still held, because the synchronized level is not visible at the ports. To reach it, the stimulus holds a line high for longer than the synchronizer delay, writes zero to the pending register, then releases the line. It then checks that the flag survived and can be cleared afterwards. Table entries combine a short pulse on some lines with a held level on others, so the same clear word clears some bits and leaves others set. Unconnected positions are driven high to show they never latch.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int unsigned IRQC_DATA_W = 32;
   localparam int unsigned IRQC_ADDR_W = 8;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_ENA  = 2'd1,
      SEL_PEND = 2'd2
   } irqc_sel_e;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
   parameter int unsigned WIDTH  = 16,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("irqc_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (rst) chain_q[0] <= '0;
      else     chain_q[0] <= d_i;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk) begin
            if (rst) chain_q[s] <= '0;
            else     chain_q[s] <= chain_q[s-1];
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/irqc_pending.sv
module irqc_pending #(
   parameter int unsigned         NUM_SRC   = 16,
   parameter logic [NUM_SRC-1:0]  CONN_MASK = 16'hEEFF
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_SRC-1:0] src_s_i,
   input  logic               clr_we_i,
   input  logic [NUM_SRC-1:0] clr_data_i,
   output logic [NUM_SRC-1:0] pend_o
);
   logic [NUM_SRC-1:0] pend_q;
   logic [NUM_SRC-1:0] set_vec;
   logic [NUM_SRC-1:0] keep_vec;
   logic [NUM_SRC-1:0] pend_d;

   assign set_vec  = src_s_i & CONN_MASK;
   assign keep_vec = clr_we_i ? clr_data_i : '1;

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
         if (CONN_MASK[i]) begin : g_conn
            always_comb pend_d[i] = set_vec[i] | (pend_q[i] & keep_vec[i]);
         end else begin : g_open
            always_comb pend_d[i] = 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) pend_q <= '0;
      else     pend_q <= pend_d;
   end

   assign pend_o = pend_q;

   // R1
   unconnected_zero_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((pend_q & ~CONN_MASK) == '0));

   // R4
   set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      (|set_vec) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));

   // R8
   sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !clr_we_i |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
endmodule

// File: rtl/irqc_regif.sv
module irqc_regif
   import irqc_pkg::*;
#(
   parameter int unsigned       NUM_SRC  = 16,
   parameter int unsigned       ADDR_W   = IRQC_ADDR_W,
   parameter int unsigned       DATA_W   = IRQC_DATA_W,
   parameter logic [ADDR_W-1:0] ENA_OFS  = 8'hC0,
   parameter logic [ADDR_W-1:0] PEND_OFS = 8'hD0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic               we_i,
   input  logic [DATA_W-1:0]  wdata_i,
   input  logic [NUM_SRC-1:0] pend_i,
   output logic [NUM_SRC-1:0] ena_o,
   output logic               clr_we_o,
   output logic [NUM_SRC-1:0] clr_data_o,
   output logic [DATA_W-1:0]  rdata_o
);
   localparam int unsigned PAD_W = DATA_W - NUM_SRC;

   generate
      if (NUM_SRC >= DATA_W) begin : g_bad_width
         $error("irqc_regif: NUM_SRC must be below DATA_W");
      end
      if (ENA_OFS == PEND_OFS) begin : g_bad_map
         $error("irqc_regif: register offsets must differ");
      end
   endgenerate

   irqc_sel_e          sel;
   logic [NUM_SRC-1:0] ena_q;
   logic [NUM_SRC-1:0] rd_val;
   logic               unused_wdata_hi;

   assign unused_wdata_hi = ^wdata_i[DATA_W-1:NUM_SRC];

   always_comb begin
      if (addr_i == ENA_OFS)       sel = SEL_ENA;
      else if (addr_i == PEND_OFS) sel = SEL_PEND;
      else                         sel = SEL_NONE;
   end

   always_ff @(posedge clk) begin
      if (rst)                          ena_q <= '0;
      else if (we_i && sel == SEL_ENA)  ena_q <= wdata_i[NUM_SRC-1:0];
   end

   assign clr_we_o   = we_i && (sel == SEL_PEND);
   assign clr_data_o = wdata_i[NUM_SRC-1:0];

   always_comb begin
      case (sel)
         SEL_ENA:  rd_val = ena_q;
         SEL_PEND: rd_val = pend_i;
         default:  rd_val = '0;
      endcase
   end

   assign rdata_o = {{PAD_W{1'b0}}, rd_val};
   assign ena_o   = ena_q;

   // R2
   ena_write_chk: assert property (@(posedge clk) disable iff (rst)
      (we_i && addr_i == ENA_OFS) |=> (ena_q == $past(wdata_i[NUM_SRC-1:0])));

   // R2
   rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |-> (rdata_o[DATA_W-1:NUM_SRC] == '0));
endmodule

// File: rtl/irq_collector.sv
module irq_collector
   import irqc_pkg::*;
#(
   parameter int unsigned        NUM_SRC     = 16,
   parameter int unsigned        SYNC_STAGES = 2,
   parameter logic [NUM_SRC-1:0] CONN_MASK   = 16'hEEFF,
   parameter logic [7:0]         ENA_OFS     = 8'hC0,
   parameter logic [7:0]         PEND_OFS    = 8'hD0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [7:0]         bus_addr_i,
   input  logic               bus_we_i,
   input  logic [31:0]        bus_wdata_i,
   output logic [31:0]        bus_rdata_o,
   input  logic [NUM_SRC-1:0] src_i,
   output logic               irq_n_o
);
   logic [NUM_SRC-1:0] src_s;
   logic [NUM_SRC-1:0] pend;
   logic [NUM_SRC-1:0] ena;
   logic               clr_we;
   logic [NUM_SRC-1:0] clr_data;
   logic               any_active;
   logic               irq_n_q;

   irqc_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) i_sync (
      .clk (clk),
      .rst (rst),
      .d_i (src_i),
      .q_o (src_s)
   );

   irqc_pending #(.NUM_SRC(NUM_SRC), .CONN_MASK(CONN_MASK)) i_pending (
      .clk        (clk),
      .rst        (rst),
      .src_s_i    (src_s),
      .clr_we_i   (clr_we),
      .clr_data_i (clr_data),
      .pend_o     (pend)
   );

   irqc_regif #(
      .NUM_SRC  (NUM_SRC),
      .ADDR_W   (IRQC_ADDR_W),
      .DATA_W   (IRQC_DATA_W),
      .ENA_OFS  (ENA_OFS),
      .PEND_OFS (PEND_OFS)
   ) i_regif (
      .clk        (clk),
      .rst        (rst),
      .addr_i     (bus_addr_i),
      .we_i       (bus_we_i),
      .wdata_i    (bus_wdata_i),
      .pend_i     (pend),
      .ena_o      (ena),
      .clr_we_o   (clr_we),
      .clr_data_o (clr_data),
      .rdata_o    (bus_rdata_o)
   );

   assign any_active = |(pend & ena);

   always_ff @(posedge clk) begin
      if (rst) irq_n_q <= 1'b1;
      else     irq_n_q <= ~any_active;
   end

   assign irq_n_o = irq_n_q;

   // R6
   summary_track_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (irq_n_q == !$past(any_active)));

   // R7
   reset_state_chk: assert property (@(posedge clk)
      rst |=> (irq_n_q && pend == '0 && ena == '0 && src_s == '0));
endmodule

// File: tb/test_irq_collector.sv
module test_irq_collector;
   localparam logic [7:0] A_ENA  = 8'hC0;
   localparam logic [7:0] A_PEND = 8'hD0;

   typedef struct packed {
      logic [15:0] pulse;
      logic [15:0] hold;
      logic [15:0] ena;
      logic [15:0] clr;
      logic [15:0] exp_pend;
      logic        exp_n;
   } vec_t;

   // pulse lines, then hold lines, then enable, clear word, expected pending, expected irq_n
   localparam vec_t VECS [0:6] = '{
      {16'h0001, 16'h0000, 16'h0001, 16'hFFFF, 16'h0001, 1'b0},
      {16'h0009, 16'h0000, 16'h0001, 16'hFFFE, 16'h0008, 1'b1},
      {16'h1100, 16'h0000, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b1},
      {16'h8004, 16'h8000, 16'h8000, 16'h0000, 16'h8000, 1'b0},
      {16'hFFFF, 16'h0000, 16'h00F0, 16'h5555, 16'h4455, 1'b0},
      {16'h0F00, 16'h0200, 16'h0F00, 16'h0000, 16'h0200, 1'b0},
      {16'h7000, 16'h1000, 16'hFFFF, 16'h0000, 16'h0000, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  bus_addr_i = '0;
   logic        bus_we_i = 1'b0;
   logic [31:0] bus_wdata_i = '0;
   logic [31:0] bus_rdata_o;
   logic [15:0] src_i = '0;
   logic        irq_n_o;

   int n_chk  = 0;
   int n_fail = 0;
   logic [31:0] rd;

   always #4 clk = ~clk;

   irq_collector i_irq_collector (
      .clk         (clk),
      .rst         (rst),
      .bus_addr_i  (bus_addr_i),
      .bus_we_i    (bus_we_i),
      .bus_wdata_i (bus_wdata_i),
      .bus_rdata_o (bus_rdata_o),
      .src_i       (src_i),
      .irq_n_o     (irq_n_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      for (int k = 0; k < n; k++) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr_i = a; bus_wdata_i = d; bus_we_i = 1'b1;
      @(negedge clk);
      bus_we_i = 1'b0;
   endtask

   task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr_i = a;
      #1 d = bus_rdata_o;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      wait_clk(5);
      rst = 1'b0;
      wait_clk(1);

      // R7 reset state
      bus_rd(A_ENA, rd);  check("R7 ena after reset", rd, 32'h0);
      bus_rd(A_PEND, rd); check("R7 pend after reset", rd, 32'h0);
      check("R7 irq_n after reset", {31'b0, irq_n_o}, 32'h1);

      // R2 upper bits read zero, full enable width
      bus_wr(A_ENA, 32'hFFFF_FFFF);
      bus_rd(A_ENA, rd); check("R2 ena readback", rd, 32'h0000_FFFF);

      // table walk
      for (int v = 0; v < 7; v++) begin
         src_i = '0;
         wait_clk(4);
         bus_wr(A_PEND, 32'h0);
         src_i = VECS[v].pulse;
         wait_clk(4);
         src_i = VECS[v].hold;
         wait_clk(4);
         bus_wr(A_ENA, {16'h0, VECS[v].ena});
         bus_wr(A_PEND, {16'h0, VECS[v].clr});
         wait_clk(4);
         // R1 R3 R4 R8 pending contents
         bus_rd(A_PEND, rd); check($sformatf("R3 table %0d pend", v), rd, {16'h0, VECS[v].exp_pend});
         bus_rd(A_ENA, rd);  check($sformatf("R2 table %0d ena", v), rd, {16'h0, VECS[v].ena});
         check($sformatf("R6 table %0d irq_n", v), {31'b0, irq_n_o}, {31'b0, VECS[v].exp_n});
      end

      // clean up
      src_i = '0;
      wait_clk(4);
      bus_wr(A_PEND, 32'h0);
      bus_wr(A_ENA, 32'h0000_0001);
      bus_addr_i = A_PEND;
      wait_clk(2);

      // R5 synchronizer latency
      src_i[0] = 1'b1;
      wait_clk(2);
      #1 check("R5 not set after two edges", bus_rdata_o, 32'h0);
      wait_clk(1);
      #1 check("R5 set after three edges", bus_rdata_o, 32'h1);
      check("R6 irq_n still high", {31'b0, irq_n_o}, 32'h1);
      wait_clk(1);
      check("R6 irq_n low one cycle later", {31'b0, irq_n_o}, 32'h0);

      // R4 clear ignored while source held
      bus_wr(A_PEND, 32'h0);
      wait_clk(2);
      bus_rd(A_PEND, rd); check("R4 clear blocked by held source", rd, 32'h1);
      check("R4 irq_n stays low", {31'b0, irq_n_o}, 32'h0);

      // R8 sticky after release
      src_i[0] = 1'b0;
      wait_clk(4);
      bus_rd(A_PEND, rd); check("R8 pending kept after release", rd, 32'h1);

      // R3 / R6 clear, then summary rises and falls again
      bus_wr(A_PEND, 32'h0);
      wait_clk(1);
      bus_rd(A_PEND, rd); check("R3 clear after release", rd, 32'h0);
      check("R6 irq_n returns high", {31'b0, irq_n_o}, 32'h1);
      bus_wr(A_ENA, 32'h0000_0008);
      src_i[3] = 1'b1;
      wait_clk(5);
      check("R6 new falling edge", {31'b0, irq_n_o}, 32'h0);
      src_i[3] = 1'b0;
      src_i[0] = 1'b1;
      wait_clk(4);
      src_i[0] = 1'b0;
      wait_clk(4);
      // R3 ones keep: clear only bit 3
      bus_wr(A_PEND, 32'h0000_FFF7);
      wait_clk(1);
      bus_rd(A_PEND, rd); check("R3 ones keep other bits", rd, 32'h0000_0001);

      // R1 unconnected bits driven high never latch
      src_i = 16'h1100;
      wait_clk(5);
      bus_rd(A_PEND, rd); check("R1 bits 8 and 12 stay zero", rd, 32'h0000_0001);
      src_i = '0;

      // R7 reset mid-operation
      bus_wr(A_ENA, 32'h0000_0001);
      wait_clk(2);
      check("R7 precondition irq_n low", {31'b0, irq_n_o}, 32'h0);
      rst = 1'b1;
      wait_clk(2);
      rst = 1'b0;
      bus_rd(A_PEND, rd); check("R7 pend cleared by reset", rd, 32'h0);
      bus_rd(A_ENA, rd);  check("R7 ena cleared by reset", rd, 32'h0);
      check("R7 irq_n high after reset", {31'b0, irq_n_o}, 32'h1);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule